// File: doc/BRIEF.md
# Call, Interrupt and Return Stack Sequencer

This block owns the program counter, the status word and the stack pointer of a small processor, and runs the four control sequences that move them through memory: subroutine call, return from subroutine, interrupt entry and return from interrupt. It drives a single-port word memory with a combinational read path. It makes at most one memory access in each state of a sequence. The stack is full descending: a push first lowers the stack pointer and then writes to the word it now points at.

A call occupies two words. The call word sits at the current program counter and its target is in the next word. The return address saved on the stack is the word after the target field. On an interrupt the block saves the program counter and then the status word. It then reads a new status word from the vector address and a new program counter from the word after it. Return from interrupt undoes this: it pops the status word first and then the program counter. Instruction decode is done elsewhere. The decoder names the sequence on `opSel` and pulses `start`.

Top module: `stack_seq_top`

## Requirements
- R1: Every push first decrements the stack pointer and then writes the pushed word at the decremented address, so after a write strobe `spOut` equals the address just written.
- R2: A call (opSel=2'b00) with PC=A reads its target from M[A+1], writes A+2 at SP-1, and ends with PC=target and SP lowered by one. It takes 2 busy cycles.
- R3: A return from subroutine (opSel=2'b01) loads PC from M[SP] and raises SP by one. It takes 1 busy cycle.
- R4: Interrupt entry writes PC at SP-1 and then the status word at SP-2, leaving SP lowered by two.
- R5: Interrupt entry captures `irqVector` when the request is accepted. It loads the status word from M[vector] and then PC from M[vector+1]. The whole entry takes 4 busy cycles.
- R6: A return from interrupt (opSel=2'b10) loads the status word from M[SP], then PC from M[SP+1], and raises SP by two. It takes 2 busy cycles.
- R7: `busy` rises in the cycle after a sequence is accepted and stays high through the cycle of the last register update.
- R8: `done` is a one-cycle pulse in the first cycle after `busy` falls. It is never high together with `busy`.
- R9: `irqReq` is sampled only while the block is idle. A request that is raised and dropped while the block is busy starts nothing. When `irqReq` and `start` arrive together in idle, the interrupt wins and the `start` is dropped.
- R10: `start` while busy is ignored, and opSel=2'b11 starts nothing.
- R11: After reset PC=PC_RESET, SP=SP_RESET, the status word is 0, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the sequence named by opSel |
| opSel | input | 2 | 00 call, 01 return, 10 return from interrupt, 11 none |
| irqReq | input | 1 | Interrupt request, level, sampled in idle |
| irqVector | input | AW | Vector address, captured with the request |
| memAddr | output | AW | Memory word address |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read strobe |
| memWdata | output | DW | Memory write data |
| memRdata | input | DW | Memory read data, combinational from memAddr |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pcOut | output | AW | Program counter |
| spOut | output | AW | Stack pointer |
| pswOut | output | DW | Status word |

## Verification
A wrong state step in the control shows at the ports at once. The busy length for that sequence comes out different, or a write strobe appears at an address other than SP-1, in the same cycle as the fault. A wrong datapath register appears in the register outputs when `done` rises. It also appears in the stack words in memory. A chained run of call, return, interrupt, nested call, return and return from interrupt carries any slip in SP or in the order of the saved words forward. As a result, the final PC, SP and status word all differ from the pre-interrupt values a few sequences later.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  typedef enum logic [1:0] {
    OP_CALL = 2'b00,
    OP_RET  = 2'b01,
    OP_RETI = 2'b10,
    OP_NONE = 2'b11
  } opCode_t;

  typedef enum logic [1:0] {
    ADR_PC_NEXT = 2'b00,
    ADR_SP_DOWN = 2'b01,
    ADR_SP      = 2'b10,
    ADR_TMP     = 2'b11
  } addrSel_t;

  typedef enum logic [1:0] {
    WD_RET_ADDR = 2'b00,
    WD_PC       = 2'b01,
    WD_PSW      = 2'b10
  } wdSel_t;

  typedef struct packed {
    logic     memWe;
    logic     memRe;
    addrSel_t addrSel;
    wdSel_t   wdSel;
    logic     spDec;
    logic     spInc;
    logic     pcFromMem;
    logic     pcFromTmp;
    logic     pswFromMem;
    logic     tmpFromMem;
    logic     tmpFromVec;
    logic     tmpInc;
  } strobe_t;

endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] opSel,
  input  logic       irqReq,
  output strobe_t    strobe,
  output logic       busy,
  output logic       done
);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CALL_TGT,
    ST_CALL_PUSH,
    ST_RET_POP,
    ST_IRQ_PC,
    ST_IRQ_PSW,
    ST_IRQ_LDPSW,
    ST_IRQ_LDPC,
    ST_RETI_PSW,
    ST_RETI_PC
  } state_t;

  state_t state, stateNext;
  logic   doneQ;
  logic   lastStep;

  always_comb begin
    stateNext = state;
    lastStep  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (irqReq) begin
          stateNext = ST_IRQ_PC;
        end else if (start) begin
          unique case (opCode_t'(opSel))
            OP_CALL: stateNext = ST_CALL_TGT;
            OP_RET:  stateNext = ST_RET_POP;
            OP_RETI: stateNext = ST_RETI_PSW;
            OP_NONE: stateNext = ST_IDLE;
          endcase
        end
      end
      ST_CALL_TGT:  stateNext = ST_CALL_PUSH;
      ST_CALL_PUSH: begin stateNext = ST_IDLE; lastStep = 1'b1; end
      ST_RET_POP:   begin stateNext = ST_IDLE; lastStep = 1'b1; end
      ST_IRQ_PC:    stateNext = ST_IRQ_PSW;
      ST_IRQ_PSW:   stateNext = ST_IRQ_LDPSW;
      ST_IRQ_LDPSW: stateNext = ST_IRQ_LDPC;
      ST_IRQ_LDPC:  begin stateNext = ST_IDLE; lastStep = 1'b1; end
      ST_RETI_PSW:  stateNext = ST_RETI_PC;
      ST_RETI_PC:   begin stateNext = ST_IDLE; lastStep = 1'b1; end
      default:      stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe         = '0;
    strobe.addrSel = ADR_SP;
    strobe.wdSel   = WD_PC;
    unique case (state)
      ST_IDLE: begin
        strobe.tmpFromVec = irqReq;
      end
      ST_CALL_TGT: begin
        strobe.addrSel    = ADR_PC_NEXT;
        strobe.memRe      = 1'b1;
        strobe.tmpFromMem = 1'b1;
      end
      ST_CALL_PUSH: begin
        strobe.addrSel   = ADR_SP_DOWN;
        strobe.wdSel     = WD_RET_ADDR;
        strobe.memWe     = 1'b1;
        strobe.spDec     = 1'b1;
        strobe.pcFromTmp = 1'b1;
      end
      ST_RET_POP: begin
        strobe.addrSel   = ADR_SP;
        strobe.memRe     = 1'b1;
        strobe.pcFromMem = 1'b1;
        strobe.spInc     = 1'b1;
      end
      ST_IRQ_PC: begin
        strobe.addrSel = ADR_SP_DOWN;
        strobe.wdSel   = WD_PC;
        strobe.memWe   = 1'b1;
        strobe.spDec   = 1'b1;
      end
      ST_IRQ_PSW: begin
        strobe.addrSel = ADR_SP_DOWN;
        strobe.wdSel   = WD_PSW;
        strobe.memWe   = 1'b1;
        strobe.spDec   = 1'b1;
      end
      ST_IRQ_LDPSW: begin
        strobe.addrSel    = ADR_TMP;
        strobe.memRe      = 1'b1;
        strobe.pswFromMem = 1'b1;
        strobe.tmpInc     = 1'b1;
      end
      ST_IRQ_LDPC: begin
        strobe.addrSel   = ADR_TMP;
        strobe.memRe     = 1'b1;
        strobe.pcFromMem = 1'b1;
      end
      ST_RETI_PSW: begin
        strobe.addrSel    = ADR_SP;
        strobe.memRe      = 1'b1;
        strobe.pswFromMem = 1'b1;
        strobe.spInc      = 1'b1;
      end
      ST_RETI_PC: begin
        strobe.addrSel   = ADR_SP;
        strobe.memRe     = 1'b1;
        strobe.pcFromMem = 1'b1;
        strobe.spInc     = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= lastStep;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;

  // R8: done lasts one cycle and never overlaps busy
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R1: a single stack pointer step direction per cycle
  p_sp_onedir_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.spInc && strobe.spDec));

  // R10: an idle cycle without request or valid start stays idle
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !irqReq && (!start || opSel == 2'b11)) |=> !busy);

  // R9: an accepted request always enters the interrupt path
  p_irq_enter_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && irqReq) |=> (busy && strobe.memWe && strobe.wdSel == WD_PC));

endmodule

// File: rtl/stack_seq_datapath.sv
module stack_seq_datapath
  import stack_seq_pkg::*;
#(
  parameter int AW       = 12,
  parameter int DW       = 16,
  parameter int PC_RESET = 0,
  parameter int SP_RESET = 0
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobe,
  input  logic [AW-1:0] irqVector,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [AW-1:0] pcOut,
  output logic [AW-1:0] spOut,
  output logic [DW-1:0] pswOut
);

  localparam logic [AW-1:0] PC_INIT = AW'(PC_RESET);
  localparam logic [AW-1:0] SP_INIT = AW'(SP_RESET);
  localparam logic [AW-1:0] ONE     = AW'(1);
  localparam logic [AW-1:0] TWO     = AW'(2);

  logic [AW-1:0] pcQ, spQ, tmpQ;
  logic [DW-1:0] pswQ;
  logic [AW-1:0] rdAddr;

  assign rdAddr = memRdata[AW-1:0];

  always_comb begin
    unique case (strobe.addrSel)
      ADR_PC_NEXT: memAddr = pcQ + ONE;
      ADR_SP_DOWN: memAddr = spQ - ONE;
      ADR_SP:      memAddr = spQ;
      ADR_TMP:     memAddr = tmpQ;
    endcase
  end

  always_comb begin
    unique case (strobe.wdSel)
      WD_RET_ADDR: memWdata = DW'(pcQ + TWO);
      WD_PC:       memWdata = DW'(pcQ);
      WD_PSW:      memWdata = pswQ;
      default:     memWdata = DW'(pcQ);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ  <= PC_INIT;
      spQ  <= SP_INIT;
      pswQ <= '0;
      tmpQ <= '0;
    end else begin
      if (strobe.spDec)           spQ  <= spQ - ONE;
      else if (strobe.spInc)      spQ  <= spQ + ONE;
      if (strobe.pcFromMem)       pcQ  <= rdAddr;
      else if (strobe.pcFromTmp)  pcQ  <= tmpQ;
      if (strobe.pswFromMem)      pswQ <= memRdata;
      if (strobe.tmpFromVec)      tmpQ <= irqVector;
      else if (strobe.tmpFromMem) tmpQ <= rdAddr;
      else if (strobe.tmpInc)     tmpQ <= tmpQ + ONE;
    end
  end

  assign pcOut  = pcQ;
  assign spOut  = spQ;
  assign pswOut = pswQ;

  // R1: after a push the stack pointer names the word just written
  p_push_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.memWe |=> (spOut == $past(memAddr)));

  // R3: a pop reads at the old stack pointer, which then rises by one
  p_pop_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.spInc && strobe.memRe) |=> (spOut == $past(memAddr) + ONE));

  // R10: no strobe, no register change
  p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0 || (strobe.addrSel == ADR_SP && strobe.wdSel == WD_PC
      && !strobe.memWe && !strobe.memRe && !strobe.tmpFromVec))
    |=> ($stable(pcOut) && $stable(spOut) && $stable(pswOut)));

endmodule

// File: rtl/stack_seq_top.sv
module stack_seq_top
  import stack_seq_pkg::*;
#(
  parameter int AW       = 12,
  parameter int DW       = 16,
  parameter int PC_RESET = 1120,
  parameter int SP_RESET = 3560
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [1:0]    opSel,
  input  logic          irqReq,
  input  logic [AW-1:0] irqVector,
  output logic [AW-1:0] memAddr,
  output logic          memWe,
  output logic          memRe,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] pcOut,
  output logic [AW-1:0] spOut,
  output logic [DW-1:0] pswOut
);

  strobe_t strobe;

  stack_seq_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .opSel  (opSel),
    .irqReq (irqReq),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  stack_seq_datapath #(
    .AW       (AW),
    .DW       (DW),
    .PC_RESET (PC_RESET),
    .SP_RESET (SP_RESET)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .irqVector (irqVector),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .pcOut     (pcOut),
    .spOut     (spOut),
    .pswOut    (pswOut)
  );

  assign memWe = strobe.memWe;
  assign memRe = strobe.memRe;

  // R7: memory is touched only while a sequence runs
  p_mem_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || memRe) |-> busy);

endmodule

// File: tb/sim_stack_seq_top.sv
module sim_stack_seq_top;

  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    opSel = 2'b11;
  logic          irqReq = 1'b0;
  logic [AW-1:0] irqVector = '0;
  logic [AW-1:0] memAddr;
  logic          memWe, memRe;
  logic [DW-1:0] memWdata, memRdata;
  logic          busy, done;
  logic [AW-1:0] pcOut, spOut;
  logic [DW-1:0] pswOut;

  logic [DW-1:0] mem [0:(1<<AW)-1];

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  stack_seq_top #(.AW(AW), .DW(DW), .PC_RESET(1120), .SP_RESET(3560)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .irqReq(irqReq), .irqVector(irqVector),
    .memAddr(memAddr), .memWe(memWe), .memRe(memRe),
    .memWdata(memWdata), .memRdata(memRdata),
    .busy(busy), .done(done),
    .pcOut(pcOut), .spOut(spOut), .pswOut(pswOut)
  );

  assign memRdata = mem[memAddr];
  always @(posedge clk) if (memWe) mem[memAddr] <= memWdata;

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Count busy cycles until idle; returns count, leaves us at the first idle negedge
  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 20) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic runOp(input logic [1:0] op, input int expCycles, input string req);
    int n;
    @(negedge clk);
    start = 1'b1; opSel = op;
    @(negedge clk);
    start = 1'b0; opSel = 2'b11;
    waitIdle(n);
    check(req, "busy cycles", n, expCycles);
    check("R8", "done after sequence", int'(done), 1);
    @(negedge clk);
    check("R8", "done single cycle", int'(done), 0);
  endtask

  task automatic runIrq(input logic [AW-1:0] vec, input logic withStart);
    int n;
    @(negedge clk);
    irqReq = 1'b1; irqVector = vec;
    start = withStart; opSel = 2'b00;
    @(negedge clk);
    irqReq = 1'b0; irqVector = '0; start = 1'b0; opSel = 2'b11;
    waitIdle(n);
    check("R5", "interrupt entry busy cycles", n, 4);
    check("R8", "done after entry", int'(done), 1);
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R11", "reset pc", int'(pcOut), 1120);
    check("R11", "reset sp", int'(spOut), 3560);
    check("R11", "reset psw", int'(pswOut), 0);
    check("R11", "reset busy", int'(busy), 0);
    check("R11", "reset done", int'(done), 0);
  endtask

  task automatic testCall();
    runOp(2'b00, 2, "R2");
    check("R2", "call pc", int'(pcOut), 2720);
    check("R2", "call sp", int'(spOut), 3559);
    check("R1", "pushed return address", int'(mem[3559]), 1122);
  endtask

  task automatic testRet();
    runOp(2'b01, 1, "R3");
    check("R3", "ret pc", int'(pcOut), 1122);
    check("R3", "ret sp", int'(spOut), 3560);
  endtask

  task automatic testIrqWhileBusy();
    int n;
    // call at 1122 -> target 1500, pulse irq mid-sequence
    @(negedge clk);
    start = 1'b1; opSel = 2'b00;
    @(negedge clk);
    start = 1'b0; irqReq = 1'b1; irqVector = 12'd200;
    @(negedge clk);
    irqReq = 1'b0; start = 1'b1; opSel = 2'b01;
    @(negedge clk);
    start = 1'b0; opSel = 2'b11;
    check("R10", "start while busy ignored: done now", int'(done), 1);
    check("R9", "irq while busy ignored: busy", int'(busy), 0);
    n = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (busy) n++;
    end
    check("R9", "no late entry from busy-time irq", n, 0);
    check("R10", "pc after call only", int'(pcOut), 1500);
    check("R10", "sp after call only", int'(spOut), 3559);
    runOp(2'b01, 1, "R3");
    check("R3", "back at 1124", int'(pcOut), 1124);
  endtask

  task automatic testNoneOp();
    int n;
    @(negedge clk);
    start = 1'b1; opSel = 2'b11;
    @(negedge clk);
    start = 1'b0;
    check("R10", "op 11 busy", int'(busy), 0);
    @(negedge clk);
    check("R10", "op 11 done", int'(done), 0);
    check("R10", "op 11 pc", int'(pcOut), 1124);
    n = 0;
  endtask

  task automatic testIrqNest();
    runIrq(12'd200, 1'b1);
    check("R4", "sp after entry", int'(spOut), 3558);
    check("R4", "saved pc", int'(mem[3559]), 1124);
    check("R4", "saved psw", int'(mem[3558]), 0);
    check("R5", "new psw", int'(pswOut), 16'hA5A5);
    check("R5", "new pc", int'(pcOut), 2048);
    check("R9", "start dropped on irq tie", int'(busy), 0);
    runOp(2'b00, 2, "R2");
    check("R2", "nested call pc", int'(pcOut), 768);
    check("R1", "nested return address", int'(mem[3557]), 2050);
    runOp(2'b01, 1, "R3");
    check("R3", "nested ret pc", int'(pcOut), 2050);
    runOp(2'b10, 2, "R6");
    check("R6", "reti psw", int'(pswOut), 0);
    check("R6", "reti pc", int'(pcOut), 1124);
    check("R6", "reti sp", int'(spOut), 3560);
  endtask

  task automatic testPswOrder();
    mem[3000] = 16'h1234;
    mem[3001] = 16'h0010;
    runIrq(12'd3000, 1'b0);
    check("R5", "psw from vector word", int'(pswOut), 16'h1234);
    check("R5", "pc from vector+1", int'(pcOut), 16);
    check("R4", "psw pushed second", int'(mem[3558]), 0);
    runOp(2'b10, 2, "R6");
    check("R6", "psw popped first", int'(pswOut), 0);
    check("R6", "pc popped second", int'(pcOut), 1124);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    mem[1121] = 16'd2720;
    mem[1123] = 16'd1500;
    mem[200]  = 16'hA5A5;
    mem[201]  = 16'd2048;
    mem[2049] = 16'd768;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCall();
    testRet();
    testIrqWhileBusy();
    testNoneOp();
    testIrqNest();
    testPswOrder();
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule